// File: doc/BRIEF.md
# Video container object extractor

This block sits between a frame filter and a memory writer in a video receive path. It takes container payload double words, each with a valid strobe, a byte count and a marker on the first word of a container. It reads a fixed header at the front of every container to learn where up to three objects lie: one ancillary object and two video objects. It then forwards only the bytes that fall inside those objects, with byte enables, so that the writer stores object data and nothing else.

A running byte position is compared against each object's start offset and end position. When a word holds the last bytes of one object and the first bytes of the next, the word is split into two byte-enable lanes. The "continuing" lane carries bytes of an object that began in an earlier word. The "new" lane carries bytes of an object whose first byte is in this word. Each lane has a flag that marks ancillary data, so the writer can send it to its own memory region. A separate block input abandons the current container at once.

Objects are assumed to be non-overlapping, to start at or after byte 80 (past the header), and to be either empty or at least four bytes long.

Top module: `oe_extract`

## Requirements
- R1: While reset is held and after it, every output is 0 (valid, data, both enable lanes, flags, index) until the first qualifying input word.
- R2: A valid word with `in_newc` high is byte position 0 of a new container. It clears all object information and restarts the byte position, and it produces no object bytes itself.
- R3: If bits [7:0] of the container's word 0 equal 8'h10, bits [15:0] of word 2 appear on `index_o` with `index_vld_o` high for one cycle, one cycle after word 2. For any other value, `index_vld_o` stays low and `index_o` keeps its value.
- R4: Object descriptors are taken from the header. Each size is in bits [15:0] of word 7 (ancillary), word 14 (video 1) or word 18 (video 2). Each offset is in bits [15:0] of the word that follows its size word. An object of size 0 is unused and contributes no bytes. A full container emits exactly the sum of its object sizes.
- R5: A byte at container position p is enabled when, for a used object, offset <= p < offset + size. Lane k of a word (k = 0 is the first byte, `in_data[31:24]`) maps to enable bit 3-k. `obj_data_o` repeats the input word. Outputs appear one clock after the input word.
- R6: Bytes of an object whose offset lies within the current word go on `be_new_o`, and `new_obj_o` is high. Bytes of an object that started in an earlier word go on `be_cur_o`. A word that ends one object and starts another uses both lanes.
- R7: `anc_cur_o` and `anc_new_o` are high when the corresponding lane carries ancillary-object bytes.
- R8: `block_i` clears all object information and stops header parsing. The word presented with it and every later word emit nothing until the next new container. The byte position holds during a blocked cycle.
- R9: `in_bc` + 1 is the number of valid leading bytes in the word (3 means all four). The byte position advances by that amount, and enable bits for absent lanes are 0.
- R10: `obj_valid_o` is high exactly when at least one enable bit of either lane is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 32 | Container word, first byte in bits [31:24] |
| in_bc | input | 2 | Valid byte count minus one |
| in_newc | input | 1 | First word of a container |
| block_i | input | 1 | Abandon current container |
| obj_valid_o | output | 1 | Output word carries object bytes |
| obj_data_o | output | 32 | Forwarded word |
| be_cur_o | output | 4 | Enables for the continuing object |
| be_new_o | output | 4 | Enables for an object starting in this word |
| new_obj_o | output | 1 | An object starts in this word |
| anc_cur_o | output | 1 | Continuing lane is ancillary data |
| anc_new_o | output | 1 | New lane is ancillary data |
| index_o | output | 16 | Index field fetched from the header |
| index_vld_o | output | 1 | Index field updated this cycle |

## Verification
A wrong descriptor register or a wrong header word count shows up as enable bits that are shifted or missing in the first payload word that touches the affected object. That is one clock after that word, and the per-cycle comparison against a behavioural byte model catches it at once. A byte position that drifts under short words or blocked cycles misplaces every later boundary, so the split word shows the wrong division between its two lanes. The per-container byte totals also show lost or extra bytes even when a single word looks plausible.

// File: rtl/oe_pkg.sv
package oe_pkg;
    localparam int NSLOT        = 3;
    localparam int ANC_SLOT     = 0;
    localparam int INDEX_WORD   = 2;
    localparam logic [7:0] TYPE_INDEXED = 8'h10;
    localparam int HDR_LAST     = 19;

    typedef enum logic [1:0] {PH_WAIT, PH_HDR, PH_BODY} hdr_phase_e;

    function automatic int desc_word(input int s);
        case (s)
            0:       return 7;
            1:       return 14;
            default: return 18;
        endcase
    endfunction
endpackage

// File: rtl/oe_hdr.sv
module oe_hdr
    import oe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [15:0]                   fld_i,
    input  logic                          in_newc,
    input  logic                          blk_i,
    output logic [NSLOT-1:0]              slot_vld_o,
    output logic [NSLOT-1:0][CNT_W-1:0]   slot_off_o,
    output logic [NSLOT-1:0][CNT_W:0]     slot_end_o,
    output logic [15:0]                   index_o,
    output logic                          index_vld_o
);
    localparam int WC_W = $clog2(HDR_LAST + 1);

    typedef struct packed {
        hdr_phase_e                     ph;
        logic [WC_W-1:0]                wcnt;
        logic [7:0]                     typ;
        logic [CNT_W-1:0]               tmp;
        logic [NSLOT-1:0]               vld;
        logic [NSLOT-1:0][CNT_W-1:0]    off;
        logic [NSLOT-1:0][CNT_W:0]      fin;
        logic [15:0]                    idx;
        logic                           idxv;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.idxv = 1'b0;
        if (blk_i) begin
            st_d.ph  = PH_WAIT;
            st_d.vld = '0;
        end else if (in_valid) begin
            if (in_newc) begin
                st_d.ph   = PH_HDR;
                st_d.wcnt = WC_W'(1);
                st_d.typ  = fld_i[7:0];
                st_d.vld  = '0;
            end else if (st_q.ph == PH_HDR) begin
                if (st_q.wcnt == WC_W'(INDEX_WORD) && st_q.typ == TYPE_INDEXED) begin
                    st_d.idx  = fld_i;
                    st_d.idxv = 1'b1;
                end
                for (int s = 0; s < NSLOT; s++) begin
                    if (st_q.wcnt == WC_W'(desc_word(s)))
                        st_d.tmp = fld_i[CNT_W-1:0];
                    if (st_q.wcnt == WC_W'(desc_word(s) + 1) && st_q.tmp != '0) begin
                        st_d.vld[s] = 1'b1;
                        st_d.off[s] = fld_i[CNT_W-1:0];
                        st_d.fin[s] = {1'b0, fld_i[CNT_W-1:0]} + {1'b0, st_q.tmp};
                    end
                end
                if (st_q.wcnt == WC_W'(HDR_LAST))
                    st_d.ph = PH_BODY;
                else
                    st_d.wcnt = st_q.wcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_vld_o  = st_q.vld;
    assign slot_off_o  = st_q.off;
    assign slot_end_o  = st_q.fin;
    assign index_o     = st_q.idx;
    assign index_vld_o = st_q.idxv;

    // R4
    zero_size_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.vld & ~$past(st_q.vld)) != '0) |-> ($past(st_q.tmp) != '0));

    // R3
    index_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        index_vld_o |-> (st_q.typ == TYPE_INDEXED));
endmodule

// File: rtl/oe_lane.sv
module oe_lane
    import oe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W:0]                pos_i,
    input  logic                          present_i,
    input  logic [NSLOT-1:0]              slot_vld_i,
    input  logic [NSLOT-1:0][CNT_W-1:0]   slot_off_i,
    input  logic [NSLOT-1:0][CNT_W:0]     slot_end_i,
    input  logic [NSLOT-1:0]              starts_i,
    output logic                          hit_cur_o,
    output logic                          hit_new_o,
    output logic                          anc_cur_o,
    output logic                          anc_new_o
);
    always_comb begin
        hit_cur_o = 1'b0;
        hit_new_o = 1'b0;
        anc_cur_o = 1'b0;
        anc_new_o = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (present_i && slot_vld_i[s] &&
                pos_i >= {1'b0, slot_off_i[s]} && pos_i < slot_end_i[s]) begin
                if (starts_i[s]) begin
                    hit_new_o = 1'b1;
                    if (s == ANC_SLOT) anc_new_o = 1'b1;
                end else begin
                    hit_cur_o = 1'b1;
                    if (s == ANC_SLOT) anc_cur_o = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/oe_extract.sv
module oe_extract
    import oe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic [1:0]  in_bc,
    input  logic        in_newc,
    input  logic        block_i,
    output logic        obj_valid_o,
    output logic [31:0] obj_data_o,
    output logic [3:0]  be_cur_o,
    output logic [3:0]  be_new_o,
    output logic        new_obj_o,
    output logic        anc_cur_o,
    output logic        anc_new_o,
    output logic [15:0] index_o,
    output logic        index_vld_o
);
    localparam int PW    = CNT_W + 1;
    localparam int LANES = 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic [31:0]      data;
        logic [3:0]       be_cur;
        logic [3:0]       be_new;
        logic             newobj;
        logic             anc_c;
        logic             anc_n;
    } out_t;

    out_t o_d, o_q;

    logic [NSLOT-1:0]            slot_vld;
    logic [NSLOT-1:0][CNT_W-1:0] slot_off;
    logic [NSLOT-1:0][CNT_W:0]   slot_end;
    logic [NSLOT-1:0]            starts;
    logic [PW-1:0]               base, lim;
    logic                        emit;
    logic [LANES-1:0]            hit_cur, hit_new, lane_anc_c, lane_anc_n;

    oe_hdr #(.CNT_W(CNT_W)) u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .fld_i      (in_data[15:0]),
        .in_newc    (in_newc),
        .blk_i      (block_i),
        .slot_vld_o (slot_vld),
        .slot_off_o (slot_off),
        .slot_end_o (slot_end),
        .index_o    (index_o),
        .index_vld_o(index_vld_o)
    );

    assign emit = in_valid && !in_newc && !block_i;
    assign base = in_newc ? '0 : {1'b0, o_q.cnt};
    assign lim  = base + PW'(in_bc) + PW'(1);

    always_comb begin
        for (int s = 0; s < NSLOT; s++)
            starts[s] = slot_vld[s] && ({1'b0, slot_off[s]} >= base) &&
                        ({1'b0, slot_off[s]} < lim);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        oe_lane #(.CNT_W(CNT_W)) u_lane (
            .pos_i     (base + PW'(i)),
            .present_i (emit && (2'(i) <= in_bc)),
            .slot_vld_i(slot_vld),
            .slot_off_i(slot_off),
            .slot_end_i(slot_end),
            .starts_i  (starts),
            .hit_cur_o (hit_cur[i]),
            .hit_new_o (hit_new[i]),
            .anc_cur_o (lane_anc_c[i]),
            .anc_new_o (lane_anc_n[i])
        );
    end

    always_comb begin
        o_d = o_q;
        if (!block_i && in_valid)
            o_d.cnt = lim[CNT_W] ? {CNT_W{1'b1}} : lim[CNT_W-1:0];
        for (int i = 0; i < LANES; i++) begin
            o_d.be_cur[LANES-1-i] = hit_cur[i];
            o_d.be_new[LANES-1-i] = hit_new[i];
        end
        o_d.newobj = |hit_new;
        o_d.valid  = |(hit_cur | hit_new);
        o_d.data   = o_d.valid ? in_data : '0;
        o_d.anc_c  = |lane_anc_c;
        o_d.anc_n  = |lane_anc_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign obj_valid_o = o_q.valid;
    assign obj_data_o  = o_q.data;
    assign be_cur_o    = o_q.be_cur;
    assign be_new_o    = o_q.be_new;
    assign new_obj_o   = o_q.newobj;
    assign anc_cur_o   = o_q.anc_c;
    assign anc_new_o   = o_q.anc_n;

    // R8
    block_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |=> !obj_valid_o);

    // R2
    newc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_newc) |=> !obj_valid_o);

    // R6
    lanes_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (be_cur_o & be_new_o) == 4'h0);

    // R9
    absent_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        obj_valid_o |-> (((be_cur_o | be_new_o) & ~(4'hF << (2'd3 - $past(in_bc)))) == 4'h0));

    // R5
    needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        obj_valid_o |-> $past(in_valid));
endmodule

// File: tb/test_oe_extract.sv
module test_oe_extract;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_newc, block_i;
    logic [31:0] in_data;
    logic [1:0]  in_bc;
    logic        obj_valid_o, new_obj_o, anc_cur_o, anc_new_o, index_vld_o;
    logic [31:0] obj_data_o;
    logic [3:0]  be_cur_o, be_new_o;
    logic [15:0] index_o;

    oe_extract i_oe_extract (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_bc(in_bc), .in_newc(in_newc), .block_i(block_i),
        .obj_valid_o(obj_valid_o), .obj_data_o(obj_data_o),
        .be_cur_o(be_cur_o), .be_new_o(be_new_o), .new_obj_o(new_obj_o),
        .anc_cur_o(anc_cur_o), .anc_new_o(anc_new_o),
        .index_o(index_o), .index_vld_o(index_vld_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0, n_bad = 0;
    int bytes_seen = 0;

    logic        e_valid = 0, e_newobj = 0, e_ancc = 0, e_ancn = 0, e_idxv = 0;
    logic [31:0] e_data = 0;
    logic [3:0]  e_cur = 0, e_new = 0;
    logic [15:0] e_idx = 0;

    int m_vld[3], m_off[3], m_end[3];
    int m_active = 0, m_wcnt = 0, m_type = 0, m_tmp = 0, m_pos = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R10 valid", 32'(obj_valid_o), 32'(e_valid));
        chk("R5 data", obj_data_o, e_data);
        chk("R5/R9 be_cur", 32'(be_cur_o), 32'(e_cur));
        chk("R6 be_new", 32'(be_new_o), 32'(e_new));
        chk("R6 new_obj", 32'(new_obj_o), 32'(e_newobj));
        chk("R7 anc_cur", 32'(anc_cur_o), 32'(e_ancc));
        chk("R7 anc_new", 32'(anc_new_o), 32'(e_ancn));
        chk("R3 index", 32'(index_o), 32'(e_idx));
        chk("R3 index_vld", 32'(index_vld_o), 32'(e_idxv));
        bytes_seen += $countones(be_cur_o) + $countones(be_new_o);
    endtask

    task automatic model(input logic v, input logic [31:0] d, input logic [1:0] bc,
                         input logic nc, input logic blk);
        int nb, base, p, k;
        bit st;
        nb = int'(bc) + 1;
        base = m_pos;
        e_valid = 0; e_data = 0; e_cur = 0; e_new = 0; e_newobj = 0;
        e_ancc = 0; e_ancn = 0; e_idxv = 0;
        if (!blk && v && !nc) begin
            for (int i = 0; i < nb; i++) begin
                p = base + i;
                for (int s = 0; s < 3; s++) begin
                    if (m_vld[s] != 0 && p >= m_off[s] && p < m_end[s]) begin
                        st = (m_off[s] >= base) && (m_off[s] < base + nb);
                        if (st) begin e_new[3-i] = 1; if (s == 0) e_ancn = 1; end
                        else    begin e_cur[3-i] = 1; if (s == 0) e_ancc = 1; end
                    end
                end
            end
            e_newobj = (e_new != 0);
            e_valid  = ((e_cur | e_new) != 0);
            e_data   = e_valid ? d : 32'h0;
            if (m_active != 0 && m_wcnt == 2 && m_type == 16) begin
                e_idx = d[15:0]; e_idxv = 1;
            end
        end
        if (blk) begin
            for (int s = 0; s < 3; s++) m_vld[s] = 0;
            m_active = 0;
        end else if (v) begin
            if (nc) begin
                for (int s = 0; s < 3; s++) m_vld[s] = 0;
                m_type = int'(d[7:0]); m_wcnt = 1; m_pos = nb; m_active = 1;
            end else begin
                m_pos = (m_pos + nb > 65535) ? 65535 : m_pos + nb;
                if (m_active != 0) begin
                    if (m_wcnt == 7 || m_wcnt == 14 || m_wcnt == 18) m_tmp = int'(d[15:0]);
                    k = (m_wcnt == 8) ? 0 : (m_wcnt == 15) ? 1 : (m_wcnt == 19) ? 2 : -1;
                    if (k >= 0 && m_tmp != 0) begin
                        m_vld[k] = 1; m_off[k] = int'(d[15:0]); m_end[k] = m_off[k] + m_tmp;
                    end
                    if (m_wcnt == 19) m_active = 0; else m_wcnt++;
                end
            end
        end
    endtask

    task automatic step(input logic v, input logic [31:0] d, input logic [1:0] bc,
                        input logic nc, input logic blk);
        @(negedge clk);
        compare_all();
        model(v, d, bc, nc, blk);
        in_valid = v; in_data = d; in_bc = bc; in_newc = nc; block_i = blk;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 32'h0, 2'd3, 0, 0);
    endtask

    task automatic send(input logic [7:0] typ, input logic [15:0] idx,
                        input int o0, input int s0, input int o1, input int s1,
                        input int o2, input int s2, input int nwords,
                        input bit rnd, input int blk_at, output int snap);
        logic [31:0] w_d;
        logic [1:0]  w_bc;
        snap = -1;
        for (int w = 0; w < nwords; w++) begin
            case (w)
                0:  w_d = {24'h0, typ};
                2:  w_d = {16'h0, idx};
                7:  w_d = 32'(s0);
                8:  w_d = 32'(o0);
                14: w_d = 32'(s1);
                15: w_d = 32'(o1);
                18: w_d = 32'(s2);
                19: w_d = 32'(o2);
                default: w_d = {w[7:0], ~w[7:0], 8'h5A, w[7:0] + 8'd1};
            endcase
            w_bc = (rnd && w >= 20) ? 2'($urandom_range(0, 3)) : 2'd3;
            if (rnd && $urandom_range(0, 3) == 0) idle(1);
            step(1, w_d, w_bc, w == 0, w == blk_at);
            if (w == 0) bytes_seen = 0;
            if (w == blk_at) snap = bytes_seen;
        end
    endtask

    initial begin
        int snap;
        for (int s = 0; s < 3; s++) begin m_vld[s] = 0; m_off[s] = 0; m_end[s] = 0; end
        rst_n = 0; in_valid = 0; in_data = 0; in_bc = 0; in_newc = 0; block_i = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", 32'(obj_valid_o), 0);
        chk("R1 be", {24'h0, be_cur_o, be_new_o}, 0);
        chk("R1 flags", {28'h0, new_obj_o, anc_cur_o, anc_new_o, index_vld_o}, 0);
        chk("R1 index", 32'(index_o), 0);
        rst_n = 1;
        idle(2);

        // indexed type, all three objects, split word at bytes 88..91
        send(8'h10, 16'hBEEF, 81, 10, 91, 23, 120, 30, 45, 0, -1, snap);
        idle(2);
        chk("R4 total bytes", 32'(bytes_seen), 63);

        // non-indexed, empty video 1, random byte counts and gaps
        send(8'h22, 16'h1111, 80, 8, 300, 0, 100, 40, 90, 1, -1, snap);
        idle(2);
        chk("R4/R9 total bytes", 32'(bytes_seen), 48);

        // block in the middle of video 1
        send(8'h10, 16'h1234, 200, 0, 84, 64, 150, 20, 50, 0, 30, snap);
        idle(2);
        chk("R8 bytes before block", 32'(snap), 36);
        chk("R8 nothing after block", 32'(bytes_seen), 32'(snap));

        // container cut short by the next one
        send(8'h10, 16'hAAAA, 81, 10, 91, 23, 120, 30, 25, 0, -1, snap);
        send(8'h10, 16'h5555, 81, 10, 91, 23, 120, 30, 45, 0, -1, snap);
        idle(2);
        chk("R2 restart total", 32'(bytes_seen), 63);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule